// File: doc/BRIEF.md
# Three-State Power Mode Controller

This block holds the chip's power state and drives the clock-gating enables for the CPU, the peripheral clock domain, the display and the main oscillator. Software asks to lower power with a one-cycle request, either to Idle or to Standby. Hardware wake sources bring the chip back: a key press, a real-time-clock alarm and interrupt lines that pass a mask.

Idle stops only the CPU clock. The peripherals and the display keep running, and any valid wake source returns the chip to Operating on the next clock edge. Standby switches everything off, including the main oscillator. Only a key press or an alarm ends Standby. The block then passes through a Waking state in which only the oscillator is enabled, and it holds there for a programmable settle count before it re-enables the clocks. A status output names the source of the most recent wake.

Top module: `powerModeCtrl`

## Requirements
- R1: After reset the state code is 2'b00 (Operating), all four enables are high and wakeCause is 0.
- R2: In Operating (code 2'b00), cpuClkEn, periphClkEn, displayEn and oscEn are all high.
- R3: In Operating, reqIdle with no wake pending moves the state to Idle (code 2'b01) at the next edge. In Idle, cpuClkEn is low and the other three enables are high.
- R4: In Operating, reqStandby with no wake pending moves the state to Standby (code 2'b10) at the next edge. In Standby all four enables are low. If reqIdle and reqStandby arrive together, Standby wins.
- R5: In Idle, wakeKey, rtcAlarm or any irqPend bit whose irqMask bit is 1 returns the state to Operating at the next edge. Interrupts whose mask bit is 0 leave the state in Idle.
- R6: Standby ends only on wakeKey or rtcAlarm. Interrupt lines have no effect on the state while it is Standby.
- R7: A wake from Standby enters Waking (code 2'b11), where only oscEn is high. The state stays in Waking for exactly settleCount+1 cycles and then returns to Operating. settleCount is held stable during a wake.
- R8: In Operating, a low-power request that arrives while a wake event is pending (wakeKey, rtcAlarm or an enabled interrupt) is ignored, and the state stays Operating.
- R9: On each wake, wakeCause is loaded with 1 for a key press, 2 for an alarm or 3 for an interrupt, with the priority key > alarm > interrupt. The value holds until the next wake.
- R10: Requests are ignored in Idle, Standby and Waking. Wake inputs are ignored in Waking.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqIdle | input | 1 | Software request to enter Idle |
| reqStandby | input | 1 | Software request to enter Standby |
| wakeKey | input | 1 | Key-press wake event |
| rtcAlarm | input | 1 | Real-time-clock alarm wake event |
| irqPend | input | IRQ_W | Pending interrupt lines |
| irqMask | input | IRQ_W | Per-line interrupt enable mask |
| settleCount | input | CNT_W | Oscillator settle count, in cycles minus one |
| cpuClkEn | output | 1 | CPU clock enable |
| periphClkEn | output | 1 | Peripheral clock enable |
| displayEn | output | 1 | Display enable |
| oscEn | output | 1 | Main oscillator enable |
| powerState | output | 2 | State code: 00 Operating, 01 Idle, 10 Standby, 11 Waking |
| wakeCause | output | 2 | Source of the last wake: 0 none, 1 key, 2 alarm, 3 interrupt |

## Verification
The bench builds the block with IRQ_W=4 and CNT_W=6. With four interrupt lines, the bench can mix masked and unmasked interrupts in the same cycle. With a 6-bit count, the full settle range from 0 to 63 can be covered in a few hundred cycles. The settle counter then runs to its largest value, so the cycle in which Waking ends can be checked at both ends of the range. Simultaneous wake sources and requests that meet a pending wake are also driven and compared against the reference model on every clock.

// File: rtl/pmc_pkg.sv
package pmcPkg;
  typedef enum logic [1:0] {
    PS_OPER = 2'b00,
    PS_IDLE = 2'b01,
    PS_STBY = 2'b10,
    PS_WAKE = 2'b11
  } pwrState_e;

  typedef struct packed {
    logic cntClear;
    logic cntInc;
    logic causeLoad;
  } pmcStrobe_t;

  localparam logic [1:0] CAUSE_NONE = 2'd0;
  localparam logic [1:0] CAUSE_KEY  = 2'd1;
  localparam logic [1:0] CAUSE_RTC  = 2'd2;
  localparam logic [1:0] CAUSE_IRQ  = 2'd3;
endpackage

// File: rtl/pmc_data.sv
module pmcData
  import pmcPkg::*;
#(
  parameter int IRQ_W = 8,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  pmcStrobe_t       strobe,
  input  logic             wakeKey,
  input  logic             rtcAlarm,
  input  logic [IRQ_W-1:0] irqPend,
  input  logic [IRQ_W-1:0] irqMask,
  input  logic [CNT_W-1:0] settleCount,
  output logic             wakeAny,
  output logic             wakeExt,
  output logic             settleDone,
  output logic [1:0]       wakeCause
);
  logic [IRQ_W-1:0] irqLive;
  logic             wakeIrq;
  logic [CNT_W-1:0] settleCnt;
  logic [1:0]       causeNext;

  // per-line mask gating
  for (genvar i = 0; i < IRQ_W; i++) begin : gIrq
    assign irqLive[i] = irqPend[i] & irqMask[i];
  end

  assign wakeIrq    = |irqLive;
  assign wakeExt    = wakeKey | rtcAlarm;
  assign wakeAny    = wakeExt | wakeIrq;
  assign settleDone = (settleCnt >= settleCount);

  always_comb begin
    if (wakeKey)       causeNext = CAUSE_KEY;
    else if (rtcAlarm) causeNext = CAUSE_RTC;
    else if (wakeIrq)  causeNext = CAUSE_IRQ;
    else               causeNext = CAUSE_NONE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      settleCnt <= '0;
    end else if (strobe.cntClear) begin
      settleCnt <= '0;
    end else if (strobe.cntInc) begin
      settleCnt <= settleCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wakeCause <= CAUSE_NONE;
    end else if (strobe.causeLoad) begin
      wakeCause <= causeNext;
    end
  end
endmodule

// File: rtl/pmc_ctrl.sv
module pmcCtrl
  import pmcPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqIdle,
  input  logic       reqStandby,
  input  logic       wakeAny,
  input  logic       wakeExt,
  input  logic       settleDone,
  output pmcStrobe_t strobe,
  output logic       cpuClkEn,
  output logic       periphClkEn,
  output logic       displayEn,
  output logic       oscEn,
  output logic [1:0] powerState
);
  pwrState_e stateQ, stateD;

  always_comb begin
    stateD = stateQ;
    strobe = '0;
    unique case (stateQ)
      PS_OPER: begin
        if (!wakeAny) begin
          if (reqStandby)   stateD = PS_STBY;
          else if (reqIdle) stateD = PS_IDLE;
        end
      end
      PS_IDLE: begin
        if (wakeAny) begin
          stateD           = PS_OPER;
          strobe.causeLoad = 1'b1;
        end
      end
      PS_STBY: begin
        if (wakeExt) begin
          stateD           = PS_WAKE;
          strobe.causeLoad = 1'b1;
          strobe.cntClear  = 1'b1;
        end
      end
      PS_WAKE: begin
        if (settleDone) stateD = PS_OPER;
        else            strobe.cntInc = 1'b1;
      end
      default: stateD = PS_OPER;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= PS_OPER;
    else       stateQ <= stateD;
  end

  assign cpuClkEn    = (stateQ == PS_OPER);
  assign periphClkEn = (stateQ == PS_OPER) || (stateQ == PS_IDLE);
  assign displayEn   = (stateQ == PS_OPER) || (stateQ == PS_IDLE);
  assign oscEn       = (stateQ != PS_STBY);
  assign powerState  = stateQ;
endmodule

// File: rtl/power_mode_ctrl.sv
module powerModeCtrl
  import pmcPkg::*;
#(
  parameter int IRQ_W = 8,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqIdle,
  input  logic             reqStandby,
  input  logic             wakeKey,
  input  logic             rtcAlarm,
  input  logic [IRQ_W-1:0] irqPend,
  input  logic [IRQ_W-1:0] irqMask,
  input  logic [CNT_W-1:0] settleCount,
  output logic             cpuClkEn,
  output logic             periphClkEn,
  output logic             displayEn,
  output logic             oscEn,
  output logic [1:0]       powerState,
  output logic [1:0]       wakeCause
);
  pmcStrobe_t strobe;
  logic       wakeAny;
  logic       wakeExt;
  logic       settleDone;

  pmcCtrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .reqIdle     (reqIdle),
    .reqStandby  (reqStandby),
    .wakeAny     (wakeAny),
    .wakeExt     (wakeExt),
    .settleDone  (settleDone),
    .strobe      (strobe),
    .cpuClkEn    (cpuClkEn),
    .periphClkEn (periphClkEn),
    .displayEn   (displayEn),
    .oscEn       (oscEn),
    .powerState  (powerState)
  );

  pmcData #(.IRQ_W(IRQ_W), .CNT_W(CNT_W)) u_data (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .wakeKey     (wakeKey),
    .rtcAlarm    (rtcAlarm),
    .irqPend     (irqPend),
    .irqMask     (irqMask),
    .settleCount (settleCount),
    .wakeAny     (wakeAny),
    .wakeExt     (wakeExt),
    .settleDone  (settleDone),
    .wakeCause   (wakeCause)
  );
endmodule

// File: rtl/pmc_checker.sv
module pmcChecker #(
  parameter int IRQ_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             reqIdle,
  input logic             reqStandby,
  input logic             wakeKey,
  input logic             rtcAlarm,
  input logic [IRQ_W-1:0] irqPend,
  input logic [IRQ_W-1:0] irqMask,
  input logic             cpuClkEn,
  input logic             periphClkEn,
  input logic             displayEn,
  input logic             oscEn,
  input logic [1:0]       powerState,
  input logic [1:0]       wakeCause
);
  logic pend;
  assign pend = wakeKey || rtcAlarm || ((irqPend & irqMask) != '0);

  // R2
  oper_all_on_chk: assert property (@(posedge clk) disable iff (!rstN)
    powerState == 2'b00 |-> (cpuClkEn && periphClkEn && displayEn && oscEn));

  // R4
  stby_enter_chk: assert property (@(posedge clk) disable iff (!rstN)
    (powerState == 2'b00 && reqStandby && !pend) |=> powerState == 2'b10);

  // R5
  idle_wake_chk: assert property (@(posedge clk) disable iff (!rstN)
    (powerState == 2'b01 && pend) |=> (powerState == 2'b00 && cpuClkEn));

  // R6
  stby_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (powerState == 2'b10 && !wakeKey && !rtcAlarm) |=> powerState == 2'b10);

  // R7
  waking_exit_chk: assert property (@(posedge clk) disable iff (!rstN)
    powerState == 2'b11 |=> (powerState == 2'b11 || powerState == 2'b00));

  // R8
  pend_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    (powerState == 2'b00 && pend) |=> powerState == 2'b00);

  // R9
  cause_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (powerState == 2'b00 && $past(powerState) == 2'b00) |-> $stable(wakeCause));
endmodule

bind powerModeCtrl pmcChecker #(.IRQ_W(IRQ_W)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .reqIdle     (reqIdle),
  .reqStandby  (reqStandby),
  .wakeKey     (wakeKey),
  .rtcAlarm    (rtcAlarm),
  .irqPend     (irqPend),
  .irqMask     (irqMask),
  .cpuClkEn    (cpuClkEn),
  .periphClkEn (periphClkEn),
  .displayEn   (displayEn),
  .oscEn       (oscEn),
  .powerState  (powerState),
  .wakeCause   (wakeCause)
);

// File: tb/power_mode_ctrl_tb.sv
module powerModeCtrl_tb;
  localparam int IRQ_W = 4;
  localparam int CNT_W = 6;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             reqIdle = 1'b0, reqStandby = 1'b0;
  logic             wakeKey = 1'b0, rtcAlarm = 1'b0;
  logic [IRQ_W-1:0] irqPend = '0, irqMask = '0;
  logic [CNT_W-1:0] settleCount = '0;
  logic             cpuClkEn, periphClkEn, displayEn, oscEn;
  logic [1:0]       powerState, wakeCause;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 0;

  int mState = 0;
  int mCnt = 0;
  int mCause = 0;

  always #2 clk = ~clk;

  powerModeCtrl #(.IRQ_W(IRQ_W), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rstN(rstN), .reqIdle(reqIdle), .reqStandby(reqStandby),
    .wakeKey(wakeKey), .rtcAlarm(rtcAlarm), .irqPend(irqPend), .irqMask(irqMask),
    .settleCount(settleCount), .cpuClkEn(cpuClkEn), .periphClkEn(periphClkEn),
    .displayEn(displayEn), .oscEn(oscEn), .powerState(powerState), .wakeCause(wakeCause)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cycles);
    end
  endtask

  function automatic int causeOf();
    if (wakeKey) return 1;
    if (rtcAlarm) return 2;
    if ((irqPend & irqMask) != '0) return 3;
    return 0;
  endfunction

  task automatic modelStep();
    bit pend;
    pend = (causeOf() != 0);
    case (mState)
      0: if (!pend) begin
           if (reqStandby) mState = 2;
           else if (reqIdle) mState = 1;
         end
      1: if (pend) begin mState = 0; mCause = causeOf(); end
      2: if (wakeKey || rtcAlarm) begin mState = 3; mCnt = 0; mCause = causeOf(); end
      default: if (mCnt >= int'(settleCount)) mState = 0; else mCnt++;
    endcase
  endtask

  task automatic compareAll();
    string tag;
    case (mState)
      0: tag = "R2"; 1: tag = "R3"; 2: tag = "R4"; default: tag = "R7";
    endcase
    check(tag, powerState, mState);
    check(tag, cpuClkEn, mState == 0);
    check(tag, periphClkEn, mState <= 1);
    check(tag, displayEn, mState <= 1);
    check(tag, oscEn, mState != 2);
    check("R9", wakeCause, mCause);
  endtask

  task automatic tick();
    @(posedge clk);
    modelStep();
    @(negedge clk);
    compareAll();
  endtask

  task automatic clearIn();
    reqIdle = 0; reqStandby = 0; wakeKey = 0; rtcAlarm = 0; irqPend = '0;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      failures++;
      $display("FAIL watchdog expired");
      finishRun();
    end
  end

  task automatic standbyWake(input int settle, input bit useKey);
    int wakeCycles;
    settleCount = CNT_W'(settle);
    reqStandby = 1; tick(); clearIn();
    check("R4", powerState, 2);
    if (useKey) wakeKey = 1; else rtcAlarm = 1;
    tick(); clearIn();
    check("R7", powerState, 3);
    check("R9", wakeCause, useKey ? 1 : 2);
    wakeCycles = 1;
    while (powerState == 2'b11 && wakeCycles < 200) begin
      if (wakeCycles == 1) begin wakeKey = 1; reqIdle = 1; end  // R10 ignored in Waking
      tick(); clearIn();
      if (powerState == 2'b11) wakeCycles++;
    end
    check("R7", wakeCycles, settle + 1);
    check("R7", powerState, 0);
  endtask

  initial begin
    irqMask = 4'b0101;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", powerState, 0);
    check("R1", {cpuClkEn, periphClkEn, displayEn, oscEn}, 4'b1111);
    check("R1", wakeCause, 0);
    rstN = 1;
    repeat (3) tick();

    // R3 enter Idle, R5 masked irq ignored, enabled irq wakes
    reqIdle = 1; tick(); clearIn();
    check("R3", powerState, 1);
    irqPend = 4'b1010; tick(); tick();
    check("R5", powerState, 1);
    reqStandby = 1; tick(); clearIn();   // R10 request in Idle ignored
    check("R10", powerState, 1);
    irqPend = 4'b0100; tick(); clearIn();
    check("R5", powerState, 0);
    check("R9", wakeCause, 3);

    // R8 requests with pending wake
    reqIdle = 1; wakeKey = 1; tick(); clearIn();
    check("R8", powerState, 0);
    reqStandby = 1; rtcAlarm = 1; tick(); clearIn();
    check("R8", powerState, 0);
    reqStandby = 1; irqPend = 4'b0001; tick(); clearIn();
    check("R8", powerState, 0);
    reqIdle = 1; irqPend = 4'b1000; tick(); clearIn();  // masked: not pending
    check("R8", powerState, 1);
    rtcAlarm = 1; tick(); clearIn();
    check("R9", wakeCause, 2);

    // R4 both requests -> Standby; R6 irq ignored; R10 request ignored
    reqIdle = 1; reqStandby = 1; tick(); clearIn();
    check("R4", powerState, 2);
    irqPend = 4'b0101; tick(); tick();
    check("R6", powerState, 2);
    clearIn(); reqIdle = 1; tick(); clearIn();
    check("R10", powerState, 2);
    check("R6", oscEn, 0);
    rtcAlarm = 1; tick(); clearIn();
    check("R6", powerState, 3);
    settleCount = 6'd5;
    while (powerState != 2'b00 && cycles < 1000) tick();

    // R7 settle range ends
    standbyWake(5, 0);
    standbyWake(0, 1);
    standbyWake(63, 0);
    standbyWake(1, 1);

    // R9 priority with simultaneous sources from Idle
    reqIdle = 1; tick(); clearIn();
    wakeKey = 1; rtcAlarm = 1; irqPend = 4'b0001; tick(); clearIn();
    check("R9", wakeCause, 1);
    reqIdle = 1; tick(); clearIn();
    rtcAlarm = 1; irqPend = 4'b0100; tick(); clearIn();
    check("R9", wakeCause, 2);
    repeat (4) tick();
    check("R9", wakeCause, 2);

    finishRun();
  end
endmodule